// File: doc/BRIEF.md
# Chip-Select Bus Cycle Controller

This block runs the external bus cycles for one chip-select region. An internal master hands it a single access: an address, a size (byte, halfword or word), a direction and write data. The block runs that access on the external bus as one or more beats. One static 16-bit control word sets how each beat behaves: how many wait clocks it has, whether it ends itself or waits for an external acknowledge, how wide the attached device is, whether byte enables also drive on reads, and whether wide reads may burst.

Each beat drives the chip-select strobe and the beat address. It puts the write data, or samples the read data, only on the byte lanes that belong to the port width. It drives byte-enable or byte-write-enable strobes for those lanes. When the access is wider than the port, it becomes several beats, most significant byte first. Reads may run as one back-to-back burst, or as separate cycles with an idle clock between them. When the final beat is acknowledged, the block raises a one-clock completion pulse with the read data right-justified.

Top module: `csbc_top`

## Requirements
- R1: Control word fields are wait count in bits 13:10, auto-acknowledge in bit 8, port size in bits 7:6, byte enable on read in bit 5 and read burst enable in bit 4. Bits 15:14, 9 and 3:0, including the burst-write bit 3, have no effect on any output.
- R2: With auto-acknowledge set and a wait count of N (0 to 15), each beat lasts N+1 clocks. `int_ack` is high only in the last of them.
- R3: With auto-acknowledge clear, `int_ack` never rises. A beat lasts until the clock in which `ext_ack` is high, and it ends in that clock.
- R4: When `ext_ack` is high during a beat, the beat ends in that clock even if wait clocks remain, and `int_ack` stays low in that clock.
- R5: Port size 00 is a 32-bit port on all four lanes. 01 is an 8-bit port on lane 3 (`bus_dout[31:24]`). 10 and 11 are a 16-bit port on lanes 3 and 2. Within a port, the byte at the lowest address uses the highest lane. Mask bit i of `bus_be` and `bus_bwe` stands for bits 8i+7:8i.
- R6: `bus_bwe` marks the active lanes on write beats only. `bus_be` marks the active lanes on read beats only, and only when bit 5 is set. It never marks lanes on writes.
- R7: With bit 4 clear, a read wider than the port becomes size/port separate beats. Each beat raises `bus_start`, one clock with `bus_cs` low sits between beats, and the address steps by the port width.
- R8: With bit 4 set, a read wider than the port runs its beats back to back. `bus_start` is high only in the first clock, `bus_burst` is high throughout, and the address steps by the port width at each beat.
- R9: `req_size` is 00 byte, 01 halfword, 10 word, and the address is aligned to the size. `req_wdata` and `rdata` are right-justified, and beats carry the most significant bytes first. `done` pulses for exactly one clock, one clock after the final beat ends, with `busy` low.
- R10: A write wider than the port is always split as in R7, whatever the value of bits 4 and 3.
- R11: While reset is active, and after reset with no request, `busy`, `done`, `bus_cs`, `int_ack` and all lane strobes are low. A request is taken in a clock where `busy` is low and `req_valid` is high, and the first beat starts in the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_word | input | 16 | Static chip-select control word |
| req_valid | input | 1 | Access request |
| req_addr | input | 32 | Access byte address |
| req_size | input | 2 | Access size code |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 32 | Right-justified write data |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-clock completion pulse |
| rdata | output | 32 | Right-justified read data, valid with done |
| ext_ack | input | 1 | External transfer acknowledge |
| int_ack | output | 1 | Internally generated transfer acknowledge |
| bus_cs | output | 1 | Chip-select active (beat in progress) |
| bus_start | output | 1 | First clock of a bus cycle |
| bus_burst | output | 1 | Beat belongs to a read burst |
| bus_rd | output | 1 | Beat is a read |
| bus_addr | output | 32 | Beat address |
| bus_be | output | 4 | Byte enables on reads |
| bus_bwe | output | 4 | Byte write enables |
| bus_dout | output | 32 | Lane-steered write data |
| bus_din | input | 32 | Read data from the bus |

## Verification
The engine runs with each of the four port-size codes against byte, halfword and word accesses. This separates single-beat lane steering from multi-beat splitting, and the unaligned byte and halfword addresses show which lane is picked. The same wide read runs with burst enable on and off, and a wide write runs with burst enable on. This separates back-to-back beats from gapped ones and shows that writes ignore the burst bit. Wait counts of 0, mid-range and 15 are paired with external acknowledges before, at and without the countdown. Control words with every reserved bit set must match their clean counterparts clock for clock.

// File: rtl/csbc_pkg.sv
package csbc_pkg;
  localparam int CFG_W    = 16;
  localparam int WS_W     = 4;
  localparam int WS_LSB   = 10;
  localparam int AA_BIT   = 8;
  localparam int PS_LSB   = 6;
  localparam int BEM_BIT  = 5;
  localparam int BSTR_BIT = 4;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BEAT = 2'd1,
    ST_GAP  = 2'd2
  } seq_state_e;

  typedef struct packed {
    logic [WS_W-1:0] wait_cnt;
    logic            auto_ack;
    logic [1:0]      port_sel;
    logic            be_on_rd;
    logic            rd_burst;
  } cs_cfg_t;
endpackage

// File: rtl/csbc_cfg_decode.sv
module csbc_cfg_decode
  import csbc_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int LANES = DATA_W / 8,
  localparam int BC_W  = $clog2(LANES) + 1
) (
  input  logic [CFG_W-1:0] cfg_word,
  output cs_cfg_t          cfg,
  output logic [BC_W-1:0]  port_bytes
);
  logic unused_cfg_bits;
  assign unused_cfg_bits = ^{cfg_word[15:14], cfg_word[9], cfg_word[3:0]};

  always_comb begin
    cfg.wait_cnt = cfg_word[WS_LSB +: WS_W];
    cfg.auto_ack = cfg_word[AA_BIT];
    cfg.port_sel = cfg_word[PS_LSB +: 2];
    cfg.be_on_rd = cfg_word[BEM_BIT];
    cfg.rd_burst = cfg_word[BSTR_BIT];
    unique case (cfg.port_sel)
      2'b00:   port_bytes = BC_W'(LANES);
      2'b01:   port_bytes = BC_W'(1);
      default: port_bytes = BC_W'(2);
    endcase
  end
endmodule

// File: rtl/csbc_wait_ctr.sv
module csbc_wait_ctr #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             active,
  input  logic             auto_ack,
  input  logic             ext_ack,
  output logic             term,
  output logic             int_ack
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  logic             expired;

  assign expired = (cnt_q == '0);
  assign term    = active && (ext_ack || (auto_ack && expired));
  assign int_ack = active && auto_ack && expired && !ext_ack;

  always_comb begin
    cnt_en = load || (active && !expired);
    cnt_d  = load ? load_val : (cnt_q - 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/csbc_lane_map.sv
module csbc_lane_map #(
  parameter int DATA_W = 32,
  localparam int LANES = DATA_W / 8,
  localparam int BC_W  = $clog2(LANES) + 1,
  localparam int IDX_W = $clog2(LANES)
) (
  input  logic [IDX_W-1:0]  beat_off,
  input  logic [BC_W-1:0]   beat_bytes,
  input  logic [BC_W-1:0]   req_bytes,
  input  logic [IDX_W-1:0]  beat_idx,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] din,
  output logic [LANES-1:0]  lane_mask,
  output logic [DATA_W-1:0] dout_lanes,
  output logic [DATA_W-1:0] rd_piece
);
  logic [LANES-1:0]  width_ones;
  logic [LANES-1:0]  top_mask;
  logic [DATA_W-1:0] lane_bits;
  logic [DATA_W-1:0] top_bits;
  logic [DATA_W-1:0] w_left;
  logic [DATA_W-1:0] w_chunk;
  int                skip_bytes;

  for (genvar g = 0; g < LANES; g++) begin : g_spread
    assign lane_bits[8*g +: 8] = {8{lane_mask[g]}};
    assign top_bits[8*g +: 8]  = {8{top_mask[g]}};
  end

  always_comb begin
    width_ones = '0;
    for (int i = 0; i < LANES; i++) begin
      if (i < int'(beat_bytes)) width_ones[i] = 1'b1;
    end
    lane_mask  = width_ones << (LANES - int'(beat_off) - int'(beat_bytes));
    top_mask   = width_ones << (LANES - int'(beat_bytes));
    skip_bytes = int'(beat_idx) * int'(beat_bytes);
    w_left     = wdata << (8 * (LANES - int'(req_bytes)));
    w_chunk    = w_left << (8 * skip_bytes);
    dout_lanes = (w_chunk >> (8 * int'(beat_off))) & lane_bits;
    rd_piece   = ((din << (8 * int'(beat_off))) & top_bits) >> (8 * skip_bytes);
  end
endmodule

// File: rtl/csbc_seq.sv
module csbc_seq
  import csbc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  localparam int LANES = DATA_W / 8,
  localparam int BC_W  = $clog2(LANES) + 1,
  localparam int IDX_W = $clog2(LANES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  input  logic              req_write,
  input  logic [BC_W-1:0]   port_bytes,
  input  logic              rd_burst_en,
  input  logic              beat_term,
  input  logic [DATA_W-1:0] rd_piece,
  output logic              busy,
  output logic              beat_active,
  output logic              beat_first,
  output logic              burst_mode,
  output logic              beat_is_rd,
  output logic              ctr_load,
  output logic [ADDR_W-1:0] beat_addr,
  output logic [IDX_W-1:0]  beat_off,
  output logic [BC_W-1:0]   beat_bytes,
  output logic [BC_W-1:0]   req_bytes,
  output logic [IDX_W-1:0]  beat_idx,
  output logic              done,
  output logic [DATA_W-1:0] rdata
);
  function automatic logic [BC_W-1:0] size_to_bytes(input logic [1:0] s);
    case (s)
      2'd0:    return BC_W'(1);
      2'd1:    return BC_W'(2);
      default: return BC_W'(LANES);
    endcase
  endfunction

  function automatic logic [BC_W-1:0] log2_pow(input logic [BC_W-1:0] v);
    log2_pow = '0;
    for (int i = 0; i < BC_W; i++) begin
      if (v[i]) log2_pow = BC_W'(i);
    end
  endfunction

  seq_state_e        state_q, state_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [BC_W-1:0]   bytes_q, bytes_d;
  logic [BC_W-1:0]   nb_q, nb_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic              wr_q, burst_q, first_q, first_d;
  logic [DATA_W-1:0] acc_q, acc_d;
  logic [DATA_W-1:0] rdata_q, rdata_d;
  logic              done_d, done_q;
  logic              accept, last_beat;
  logic              req_en, step_en, acc_en, rdata_en;
  logic [BC_W-1:0]   new_bytes;

  assign accept      = (state_q == ST_IDLE) && req_valid;
  assign new_bytes   = size_to_bytes(req_size);
  assign beat_active = (state_q == ST_BEAT);
  assign busy        = (state_q != ST_IDLE);
  assign beat_first  = beat_active && first_q;
  assign burst_mode  = beat_active && burst_q;
  assign beat_is_rd  = beat_active && !wr_q;
  assign beat_addr   = addr_q;
  assign beat_off    = addr_q[IDX_W-1:0] & IDX_W'(port_bytes - 1'b1);
  assign beat_bytes  = (bytes_q < port_bytes) ? bytes_q : port_bytes;
  assign req_bytes   = bytes_q;
  assign beat_idx    = idx_q;
  assign last_beat   = ((BC_W'(idx_q) + 1'b1) == nb_q);
  assign done        = done_q;
  assign rdata       = rdata_q;

  always_comb begin
    state_d  = state_q;
    first_d  = 1'b0;
    done_d   = 1'b0;
    ctr_load = 1'b0;
    req_en   = 1'b0;
    step_en  = 1'b0;
    acc_en   = 1'b0;
    rdata_en = 1'b0;
    bytes_d  = new_bytes;
    nb_d     = (new_bytes > port_bytes) ? (new_bytes >> log2_pow(port_bytes)) : BC_W'(1);
    addr_d   = addr_q + ADDR_W'(beat_bytes);
    idx_d    = idx_q + 1'b1;
    acc_d    = acc_q | rd_piece;
    rdata_d  = acc_d >> (8 * (LANES - int'(bytes_q)));
    unique case (state_q)
      ST_IDLE: begin
        if (accept) begin
          state_d  = ST_BEAT;
          first_d  = 1'b1;
          ctr_load = 1'b1;
          req_en   = 1'b1;
          acc_en   = 1'b1;
          acc_d    = '0;
        end
      end
      ST_BEAT: begin
        if (beat_term) begin
          acc_en = !wr_q;
          if (last_beat) begin
            state_d  = ST_IDLE;
            done_d   = 1'b1;
            rdata_en = !wr_q;
          end else begin
            step_en = 1'b1;
            if (burst_q) begin
              ctr_load = 1'b1;
            end else begin
              state_d = ST_GAP;
            end
          end
        end
      end
      ST_GAP: begin
        state_d  = ST_BEAT;
        first_d  = 1'b1;
        ctr_load = 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      first_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      first_q <= first_d;
      done_q  <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      bytes_q <= BC_W'(1);
      nb_q    <= BC_W'(1);
      wr_q    <= 1'b0;
      burst_q <= 1'b0;
      idx_q   <= '0;
    end else if (req_en) begin
      addr_q  <= req_addr;
      bytes_q <= bytes_d;
      nb_q    <= nb_d;
      wr_q    <= req_write;
      burst_q <= !req_write && rd_burst_en && (nb_d > BC_W'(1));
      idx_q   <= '0;
    end else if (step_en) begin
      addr_q  <= addr_d;
      idx_q   <= idx_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
    end else if (acc_en) begin
      acc_q <= acc_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (rdata_en) begin
      rdata_q <= rdata_d;
    end
  end
endmodule

// File: rtl/csbc_top.sv
module csbc_top
  import csbc_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2,
  localparam int LANES      = DATA_W / 8,
  localparam int BC_W       = $clog2(LANES) + 1,
  localparam int IDX_W      = $clog2(LANES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CFG_W-1:0]  cfg_word,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  input  logic              req_write,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rdata,
  input  logic              ext_ack,
  output logic              int_ack,
  output logic              bus_cs,
  output logic              bus_start,
  output logic              bus_burst,
  output logic              bus_rd,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [LANES-1:0]  bus_be,
  output logic [LANES-1:0]  bus_bwe,
  output logic [DATA_W-1:0] bus_dout,
  input  logic [DATA_W-1:0] bus_din
);
  logic [SYNC_STAGES-1:0] rst_pipe_q;
  logic                   rst_n_s;
  cs_cfg_t                cfg;
  logic [BC_W-1:0]        port_bytes;
  logic                   beat_term, ctr_load, beat_active, beat_is_rd;
  logic [IDX_W-1:0]       beat_off, beat_idx;
  logic [BC_W-1:0]        beat_bytes, req_bytes;
  logic [LANES-1:0]       lane_mask;
  logic [DATA_W-1:0]      dout_lanes, rd_piece;
  logic                   wr_beat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= '0;
    end else begin
      rst_pipe_q <= {rst_pipe_q[SYNC_STAGES-2:0], 1'b1};
    end
  end
  assign rst_n_s = rst_pipe_q[SYNC_STAGES-1];

  csbc_cfg_decode #(.DATA_W(DATA_W)) u_dec (
    .cfg_word  (cfg_word),
    .cfg       (cfg),
    .port_bytes(port_bytes)
  );

  csbc_wait_ctr #(.CNT_W(WS_W)) u_ctr (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .load    (ctr_load),
    .load_val(cfg.wait_cnt),
    .active  (beat_active),
    .auto_ack(cfg.auto_ack),
    .ext_ack (ext_ack),
    .term    (beat_term),
    .int_ack (int_ack)
  );

  csbc_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .req_valid  (req_valid),
    .req_addr   (req_addr),
    .req_size   (req_size),
    .req_write  (req_write),
    .port_bytes (port_bytes),
    .rd_burst_en(cfg.rd_burst),
    .beat_term  (beat_term),
    .rd_piece   (rd_piece),
    .busy       (busy),
    .beat_active(beat_active),
    .beat_first (bus_start),
    .burst_mode (bus_burst),
    .beat_is_rd (beat_is_rd),
    .ctr_load   (ctr_load),
    .beat_addr  (bus_addr),
    .beat_off   (beat_off),
    .beat_bytes (beat_bytes),
    .req_bytes  (req_bytes),
    .beat_idx   (beat_idx),
    .done       (done),
    .rdata      (rdata)
  );

  csbc_lane_map #(.DATA_W(DATA_W)) u_lane (
    .beat_off  (beat_off),
    .beat_bytes(beat_bytes),
    .req_bytes (req_bytes),
    .beat_idx  (beat_idx),
    .wdata     (req_wdata_q),
    .din       (bus_din),
    .lane_mask (lane_mask),
    .dout_lanes(dout_lanes),
    .rd_piece  (rd_piece)
  );

  logic [DATA_W-1:0] req_wdata_q;
  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      req_wdata_q <= '0;
    end else if (req_valid && !busy) begin
      req_wdata_q <= req_wdata;
    end
  end

  assign wr_beat  = beat_active && !beat_is_rd;
  assign bus_cs   = beat_active;
  assign bus_rd   = beat_is_rd;
  assign bus_be   = (beat_is_rd && cfg.be_on_rd) ? lane_mask : '0;
  assign bus_bwe  = wr_beat ? lane_mask : '0;
  assign bus_dout = wr_beat ? dout_lanes : '0;
endmodule

// File: rtl/csbc_checker.sv
module csbc_checker #(
  parameter int ADDR_W = 32,
  parameter int LANES  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [15:0]       cfg_word,
  input logic              busy,
  input logic              done,
  input logic              ext_ack,
  input logic              int_ack,
  input logic              bus_cs,
  input logic              bus_start,
  input logic              bus_burst,
  input logic              bus_rd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [LANES-1:0]  bus_be,
  input logic [LANES-1:0]  bus_bwe
);
  localparam logic [LANES-1:0] TOP_LANE = LANES'(1) << (LANES - 1);

  AST_INT_ACK_NEEDS_AA: assert property (@(posedge clk) disable iff (!rst_n)
    int_ack |-> cfg_word[8]); // R3
  AST_INT_ACK_IN_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    int_ack |-> bus_cs); // R2
  AST_EXT_ACK_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    ext_ack |-> !int_ack); // R4
  AST_EXT_ACK_ENDS_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cs && ext_ack) |=> (!bus_cs || (bus_addr != $past(bus_addr)))); // R4
  AST_NARROW_PORT_LANE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cs && cfg_word[7:6] == 2'b01) |-> (((bus_be | bus_bwe) & ~TOP_LANE) == '0)); // R5
  AST_NO_BE_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cs && !bus_rd) |-> (bus_be == '0)); // R6
  AST_NO_BWE_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |-> (bus_bwe == '0)); // R6
  AST_BURST_READ_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    bus_burst |-> (bus_rd && cfg_word[4])); // R8
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && !bus_cs)); // R9
  AST_STROBES_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_cs |-> (bus_be == '0 && bus_bwe == '0 && !int_ack && !bus_start)); // R11
endmodule

bind csbc_top csbc_checker #(.ADDR_W(ADDR_W), .LANES(LANES)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cfg_word (cfg_word),
  .busy     (busy),
  .done     (done),
  .ext_ack  (ext_ack),
  .int_ack  (int_ack),
  .bus_cs   (bus_cs),
  .bus_start(bus_start),
  .bus_burst(bus_burst),
  .bus_rd   (bus_rd),
  .bus_addr (bus_addr),
  .bus_be   (bus_be),
  .bus_bwe  (bus_bwe)
);

// File: tb/csbc_top_tb.sv
module csbc_top_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] cfg_word;
  logic        req_valid, req_write, ext_ack;
  logic [31:0] req_addr, req_wdata, bus_din;
  logic [1:0]  req_size;
  logic        busy, done, int_ack, bus_cs, bus_start, bus_burst, bus_rd;
  logic [31:0] rdata, bus_addr, bus_dout;
  logic [3:0]  bus_be, bus_bwe;
  int          n_cmp = 0;
  int          n_bad = 0;
  bit          finished = 1'b0;

  always #2 clk = ~clk;

  csbc_top u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_word(cfg_word), .req_valid(req_valid),
    .req_addr(req_addr), .req_size(req_size), .req_write(req_write),
    .req_wdata(req_wdata), .busy(busy), .done(done), .rdata(rdata),
    .ext_ack(ext_ack), .int_ack(int_ack), .bus_cs(bus_cs), .bus_start(bus_start),
    .bus_burst(bus_burst), .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_be(bus_be),
    .bus_bwe(bus_bwe), .bus_dout(bus_dout), .bus_din(bus_din)
  );

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [15:0] mk_cfg(int ws, bit aa, logic [1:0] ps, bit bem, bit bstr);
    return {2'b00, 4'(ws), 1'b0, aa, ps, bem, bstr, 4'b0000};
  endfunction

  task automatic quiet_checks(string tag);
    chk(tag, "cs", 32'(bus_cs), 0);
    chk(tag, "start", 32'(bus_start), 0);
    chk(tag, "be", 32'(bus_be), 0);
    chk(tag, "bwe", 32'(bus_bwe), 0);
    chk(tag, "int_ack", 32'(int_ack), 0);
    chk(tag, "dout", bus_dout, 0);
  endtask

  task automatic run_txn(string tag, logic [15:0] cfg, logic [31:0] addr,
                         logic [1:0] size, bit wr, logic [31:0] wd, int ad[4]);
    int ws, pb, nb, bw, n, blen, off, top;
    bit aa, bem, burst;
    logic [31:0] exp_rd, a, dv, ed;
    logic [3:0] m;
    ws = int'(cfg[13:10]);
    aa = cfg[8];
    bem = cfg[5];
    pb = (cfg[7:6] == 2'b00) ? 4 : (cfg[7:6] == 2'b01) ? 1 : 2;
    nb = (size == 2'd0) ? 1 : (size == 2'd1) ? 2 : 4;
    bw = (nb < pb) ? nb : pb;
    n = nb / bw;
    burst = !wr && cfg[4] && (n > 1);
    exp_rd = '0;
    @(negedge clk);
    cfg_word = cfg; req_valid = 1'b1; req_addr = addr; req_size = size;
    req_write = wr; req_wdata = wd; ext_ack = 1'b0; bus_din = '0;
    #1;
    chk(tag, "busy at accept", 32'(busy), 0);
    chk(tag, "done at accept", 32'(done), 0);
    for (int k = 0; k < n; k++) begin
      a = addr + 32'(k * bw);
      off = int'(a[1:0]) % pb;
      top = 3 - off;
      m = '0;
      ed = '0;
      for (int i = 0; i < bw; i++) begin
        int j = k * bw + i;
        m[top - i] = 1'b1;
        ed[8*(top - i) +: 8] = wd[8*(nb - 1 - j) +: 8];
      end
      if (!aa) blen = ad[k] + 1;
      else begin
        blen = ws + 1;
        if (ad[k] >= 0 && ad[k] + 1 < blen) blen = ad[k] + 1;
      end
      for (int c = 0; c < blen; c++) begin
        @(negedge clk);
        req_valid = 1'b0;
        ext_ack = (c == ad[k]);
        dv = 32'h8C4E1A73 ^ (32'(k) * 32'h11111111) ^ 32'(c * 7);
        bus_din = dv;
        #1;
        chk(tag, "cs", 32'(bus_cs), 1);
        chk(tag, "start", 32'(bus_start), 32'((c == 0) && (k == 0 || !burst)));
        chk(tag, "burst", 32'(bus_burst), 32'(burst));
        chk(tag, "rd", 32'(bus_rd), 32'(!wr));
        chk(tag, "addr", bus_addr, a);
        chk(tag, "be", 32'(bus_be), (!wr && bem) ? 32'(m) : 0);
        chk(tag, "bwe", 32'(bus_bwe), wr ? 32'(m) : 0);
        chk(tag, "dout", bus_dout, wr ? ed : 0);
        chk(tag, "int_ack", 32'(int_ack), 32'(aa && c == ws && c != ad[k]));
        chk(tag, "done in beat", 32'(done), 0);
        chk(tag, "busy in beat", 32'(busy), 1);
        if (c == blen - 1 && !wr) begin
          for (int i = 0; i < bw; i++) begin
            int j = k * bw + i;
            exp_rd[8*(nb - 1 - j) +: 8] = dv[8*(top - i) +: 8];
          end
        end
      end
      if (k < n - 1 && !burst) begin
        @(negedge clk);
        ext_ack = 1'b0;
        bus_din = '0;
        #1;
        quiet_checks({tag, " gap"});
        chk(tag, "busy in gap", 32'(busy), 1);
      end
    end
    @(negedge clk);
    ext_ack = 1'b0;
    bus_din = '0;
    #1;
    chk(tag, "done pulse", 32'(done), 1);
    chk(tag, "busy at done", 32'(busy), 0);
    chk(tag, "cs at done", 32'(bus_cs), 0);
    if (!wr) chk(tag, "rdata", rdata, exp_rd);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cfg_word = '0; req_valid = 1'b0; req_write = 1'b0;
    req_addr = '0; req_size = '0; req_wdata = '0; ext_ack = 1'b0; bus_din = '0;
    repeat (3) @(negedge clk);
    #1;
    chk("R11", "busy in reset", 32'(busy), 0);
    chk("R11", "done in reset", 32'(done), 0);
    quiet_checks("R11 reset");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    chk("R11", "busy after reset", 32'(busy), 0);
    quiet_checks("R11 idle");

    run_txn("R2 R5 word read 32-bit ws0", mk_cfg(0, 1, 2'b00, 0, 0), 32'h1000, 2'd2, 0, 0, '{-1, -1, -1, -1});
    run_txn("R2 word write ws3", mk_cfg(3, 1, 2'b00, 0, 0), 32'h2000, 2'd2, 1, 32'hDEADBEEF, '{-1, -1, -1, -1});
    run_txn("R5 R6 byte read lane1 bem", mk_cfg(1, 1, 2'b00, 1, 0), 32'h3002, 2'd0, 0, 0, '{-1, -1, -1, -1});
    run_txn("R6 byte write bem", mk_cfg(0, 1, 2'b00, 1, 0), 32'h3001, 2'd0, 1, 32'h000000A5, '{-1, -1, -1, -1});
    run_txn("R7 split word read 8-bit", mk_cfg(1, 1, 2'b01, 0, 0), 32'h4000, 2'd2, 0, 0, '{-1, -1, -1, -1});
    run_txn("R8 burst word read 8-bit", mk_cfg(2, 1, 2'b01, 0, 1), 32'h4100, 2'd2, 0, 0, '{-1, -1, -1, -1});
    run_txn("R5 R8 burst word read 16-bit", mk_cfg(0, 1, 2'b10, 1, 1), 32'h5000, 2'd2, 0, 0, '{-1, -1, -1, -1});
    run_txn("R10 word write 16-bit burst bit set", mk_cfg(1, 1, 2'b11, 0, 1), 32'h5100, 2'd2, 1, 32'h01234567, '{-1, -1, -1, -1});
    run_txn("R3 no auto ack word read", mk_cfg(2, 0, 2'b00, 0, 0), 32'h6000, 2'd2, 0, 0, '{5, -1, -1, -1});
    run_txn("R3 no auto ack split half read", mk_cfg(9, 0, 2'b01, 1, 0), 32'h6010, 2'd1, 0, 0, '{0, 3, -1, -1});
    run_txn("R4 early ext ack burst", mk_cfg(7, 1, 2'b10, 0, 1), 32'h6100, 2'd2, 0, 0, '{2, 0, -1, -1});
    run_txn("R4 ext ack at expiry", mk_cfg(2, 1, 2'b00, 0, 0), 32'h6200, 2'd1, 1, 32'h0000C3D2, '{2, -1, -1, -1});
    run_txn("R1 reserved bits half read", mk_cfg(2, 1, 2'b10, 0, 0) | 16'hC20F, 32'h7002, 2'd1, 0, 0, '{-1, -1, -1, -1});
    run_txn("R1 R10 burst write bit set", mk_cfg(0, 1, 2'b01, 0, 0) | 16'hC20F, 32'h7100, 2'd2, 1, 32'hFEDCBA98, '{-1, -1, -1, -1});
    run_txn("R2 max wait byte write", mk_cfg(15, 1, 2'b01, 0, 0), 32'h7203, 2'd0, 1, 32'h0000005A, '{-1, -1, -1, -1});
    run_txn("R9 half write 16-bit upper", mk_cfg(0, 1, 2'b10, 0, 0), 32'h7302, 2'd1, 1, 32'h00009B7E, '{-1, -1, -1, -1});
    run_txn("R9 half read 32-bit", mk_cfg(1, 1, 2'b00, 1, 1), 32'h7402, 2'd1, 0, 0, '{-1, -1, -1, -1});

    @(negedge clk);
    #1;
    chk("R9", "done single pulse", 32'(done), 0);
    chk("R11", "idle busy", 32'(busy), 0);
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule